// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This controller brings a display link up and takes it down in a safe order. It drives five strobes: panel supply enable, video-source enable, a black-pixel select, a serializer enable (active high, low means the serializer is held in shutdown), and backlight enable. A power-on request walks the link through these steps:

- supply ramp and settle
- black video
- serializer release
- a lock hold on black
- real image
- backlight

A power-off request walks it back down. The black interval before shutdown is timed by counting frame-start pulses from the video timing.

Waits on the millisecond scale are counted in microseconds from one shared prescaler, whose divide ratio is a parameter. The supply-ramp, settle and backlight-off times are configuration inputs. They are captured only while the block is idle off. A power-off request that arrives while powering up stops the climb and joins the power-down path at the step that matches the strobes already asserted. If frame pulses stop while black frames are being counted, a fault flag is raised and shutdown goes ahead anyway.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, panel_pwr_en, video_en, ser_enable and backlight_en are 0, black_sel is 1, seq_status is 0 (off), and seq_done and frame_fault are 0.
- R2: On a power-on request in the off state, the strobe vector {panel_pwr_en, video_en, ser_enable, black_sel, backlight_en} steps through 10010, 11010, 11110, 11100, 11101. The step from 11010 to 11110 and the step from 11100 to 11101 each take exactly one cycle.
- R3: The time from panel power-on to video enable is more than (cfg_ramp_us + cfg_settle_us) microseconds and at most that plus 2 us plus 4 cycles.
- R4: After ser_enable rises, black_sel stays 1 for more than LOCK_US microseconds (default 1001) and at most one microsecond plus 2 cycles longer.
- R5: On a power-off request in the on state, the vector steps through 11100, 11110, 11010, 10010, 00010. The last step takes one cycle.
- R6: The step from backlight off to black select takes more than cfg_bloff_us microseconds and at most one microsecond plus 2 cycles longer.
- R7: ser_enable falls only after BLACK_FRAMES (default 3) frame_start pulses have been seen with black_sel high during power-down. This is more than two full frame periods.
- R8: video_en falls exactly ceil(CYC_PER_US*250/1000)+1 cycles after ser_enable falls, which is never less than 250 ns.
- R9: A power-off request during power-up aborts it. From supply ramp or settle, the block goes straight to off without enabling video. From the black-video step, it goes to shutdown. From lock hold or image, it goes to black-frame counting.
- R10: pwr_on_req is ignored unless the block is off. pwr_off_req is ignored when the block is off or powering down.
- R11: The configuration inputs are captured only in the off state. Changing them at any other time does not alter the sequence already in progress.
- R12: seq_status is 0 when off, 1 when powering up, 2 when on and 3 when powering down. seq_done pulses for one cycle on entry to on and on entry to off.
- R13: If no frame_start pulse arrives for FRAME_TO_US microseconds while black frames are being counted, frame_fault is set and shutdown proceeds. frame_fault stays set until the next accepted power-on request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Request to bring the link up |
| pwr_off_req | input | 1 | Request to take the link down |
| frame_start | input | 1 | One-cycle pulse at each frame start |
| cfg_ramp_us | input | CFG_W | Supply ramp time in microseconds |
| cfg_settle_us | input | CFG_W | Extra settle time in microseconds |
| cfg_bloff_us | input | CFG_W | Backlight-off wait in microseconds |
| panel_pwr_en | output | 1 | Panel supply enable |
| video_en | output | 1 | Video-source enable |
| black_sel | output | 1 | Force video to black pixels |
| ser_enable | output | 1 | Serializer enable (low = shutdown) |
| backlight_en | output | 1 | Backlight enable |
| seq_status | output | 2 | 0 off, 1 powering up, 2 on, 3 powering down |
| seq_done | output | 1 | One-cycle pulse on reaching on or off |
| frame_fault | output | 1 | Frame pulses stopped during black counting |

## Verification
The bench measures the gap in cycles between consecutive strobe changes and checks each gap against a window derived from the programmed microsecond counts. A timer that counts one tick short, or that ignores the shared tick, therefore lands outside its window. Power-off requests injected in the ramp and lock steps check that the climb stops at the right step. A design that mapped the abort wrongly would briefly enable video or skip black frames, and the scoreboard would see an unexpected vector. The bench stops frame pulses during power-down to prove that shutdown still happens and the fault is latched, then checks that the fault clears on the next power-up. It also rewrites the backlight-off time while the link is on and checks that the previously captured value still governs.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_RAMP,
        S_SETTLE,
        S_VID_BLACK,
        S_LOCK,
        S_IMG,
        S_ON,
        S_BL_OFF,
        S_BLK_FRAMES,
        S_SHDN,
        S_PANEL_OFF
    } seq_state_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_ON   = 2'd2,
        ST_DOWN = 2'd3
    } seq_status_e;

    typedef struct packed {
        logic panel;
        logic video;
        logic ser;
        logic black;
        logic bl;
    } link_ctl_t;

    function automatic link_ctl_t ctl_of(seq_state_e s);
        link_ctl_t c;
        c = '{panel: 1'b0, video: 1'b0, ser: 1'b0, black: 1'b1, bl: 1'b0};
        case (s)
            S_RAMP, S_SETTLE, S_PANEL_OFF: c.panel = 1'b1;
            S_VID_BLACK, S_SHDN: begin
                c.panel = 1'b1;
                c.video = 1'b1;
            end
            S_LOCK, S_BLK_FRAMES: begin
                c.panel = 1'b1;
                c.video = 1'b1;
                c.ser   = 1'b1;
            end
            S_IMG, S_BL_OFF: begin
                c.panel = 1'b1;
                c.video = 1'b1;
                c.ser   = 1'b1;
                c.black = 1'b0;
            end
            S_ON: begin
                c.panel = 1'b1;
                c.video = 1'b1;
                c.ser   = 1'b1;
                c.black = 1'b0;
                c.bl    = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic seq_status_e status_of(seq_state_e s);
        case (s)
            S_OFF:                                    return ST_OFF;
            S_ON:                                     return ST_ON;
            S_RAMP, S_SETTLE, S_VID_BLACK, S_LOCK,
            S_IMG:                                    return ST_UP;
            default:                                  return ST_DOWN;
        endcase
    endfunction

    function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/lcd_us_tick.sv
module lcd_us_tick #(
    parameter int CYC_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cnt_q == LAST) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         cyc_mode,
    input  logic         tick,
    output logic         expired
);
    logic [W-1:0] cnt_q;
    logic         mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val;
            mode_q <= cyc_mode;
        end else if (cnt_q != '0 && (mode_q || tick)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_frame_watch.sv
module lcd_frame_watch #(
    parameter int GOAL  = 3,
    parameter int TO_US = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic frame_pulse,
    input  logic us_tick,
    output logic goal_met,
    output logic timed_out
);
    localparam int FW = $clog2(GOAL + 1);
    localparam int TW = $clog2(TO_US + 1);
    localparam logic [FW-1:0] GOAL_V = FW'(GOAL);
    localparam logic [TW-1:0] TO_V   = TW'(TO_US);

    logic [FW-1:0] frames_q;
    logic [TW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst || clr)                                frames_q <= '0;
        else if (en && frame_pulse && frames_q != GOAL_V) frames_q <= frames_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)                              idle_q <= '0;
        else if (en && frame_pulse)                  idle_q <= '0;
        else if (en && us_tick && idle_q != TO_V)    idle_q <= idle_q + 1'b1;
    end

    assign goal_met  = (frames_q == GOAL_V);
    assign timed_out = (idle_q == TO_V);
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter int CYC_PER_US   = 100,
    parameter int CFG_W        = 18,
    parameter int LOCK_US      = 1001,
    parameter int BLACK_FRAMES = 3,
    parameter int FRAME_TO_US  = 40000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_on_req,
    input  logic             pwr_off_req,
    input  logic             frame_start,
    input  logic [CFG_W-1:0] cfg_ramp_us,
    input  logic [CFG_W-1:0] cfg_settle_us,
    input  logic [CFG_W-1:0] cfg_bloff_us,
    output logic             panel_pwr_en,
    output logic             video_en,
    output logic             black_sel,
    output logic             ser_enable,
    output logic             backlight_en,
    output logic [1:0]       seq_status,
    output logic             seq_done,
    output logic             frame_fault
);
    localparam int LOCK_W   = $clog2(LOCK_US + 2);
    localparam int TMR_W    = ((CFG_W > LOCK_W) ? CFG_W : LOCK_W) + 1;
    localparam int SHDN_CYC = ceil_div(CYC_PER_US * 250, 1000);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    seq_state_e       st_q, st_d;
    logic [CFG_W-1:0] ramp_q, settle_q, bloff_q;
    logic             us_tick;
    logic             tmr_load, tmr_cyc, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic             fw_clr, fw_en, fw_goal, fw_to;
    logic             done_q, fault_q;
    link_ctl_t        ctl;

    lcd_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(us_tick)
    );

    lcd_seq_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .cyc_mode(tmr_cyc),
        .tick    (us_tick),
        .expired (tmr_exp)
    );

    lcd_frame_watch #(.GOAL(BLACK_FRAMES), .TO_US(FRAME_TO_US)) u_frames (
        .clk        (clk),
        .rst        (rst),
        .clr        (fw_clr),
        .en         (fw_en),
        .frame_pulse(frame_start),
        .us_tick    (us_tick),
        .goal_met   (fw_goal),
        .timed_out  (fw_to)
    );

    // configuration is only captured while idle off
    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_q   <= '0;
            settle_q <= '0;
            bloff_q  <= '0;
        end else if (st_q == S_OFF) begin
            ramp_q   <= cfg_ramp_us;
            settle_q <= cfg_settle_us;
            bloff_q  <= cfg_bloff_us;
        end
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        case (st_q)
            S_OFF:        if (pwr_on_req) st_d = S_RAMP;
            S_RAMP:       if (pwr_off_req) st_d = S_PANEL_OFF;
                          else if (tmr_exp) st_d = S_SETTLE;
            S_SETTLE:     if (pwr_off_req) st_d = S_PANEL_OFF;
                          else if (tmr_exp) st_d = S_VID_BLACK;
            S_VID_BLACK:  st_d = pwr_off_req ? S_SHDN : S_LOCK;
            S_LOCK:       if (pwr_off_req) st_d = S_BLK_FRAMES;
                          else if (tmr_exp) st_d = S_IMG;
            S_IMG:        st_d = pwr_off_req ? S_BLK_FRAMES : S_ON;
            S_ON:         if (pwr_off_req) st_d = S_BL_OFF;
            S_BL_OFF:     if (tmr_exp) st_d = S_BLK_FRAMES;
            S_BLK_FRAMES: if (fw_goal || fw_to) st_d = S_SHDN;
            S_SHDN:       if (tmr_exp) st_d = S_PANEL_OFF;
            S_PANEL_OFF:  st_d = S_OFF;
            default:      st_d = S_OFF;
        endcase
    end

    // timer and frame-counter arming on entry to a waiting step
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_cyc  = 1'b0;
        fw_clr   = 1'b0;
        if (st_d != st_q) begin
            case (st_d)
                S_RAMP: begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(ramp_q) + ONE;
                end
                S_SETTLE: begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(settle_q) + ONE;
                end
                S_LOCK: begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(LOCK_US) + ONE;
                end
                S_BL_OFF: begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(bloff_q) + ONE;
                end
                S_SHDN: begin
                    tmr_load = 1'b1;
                    tmr_cyc  = 1'b1;
                    tmr_val  = TMR_W'(SHDN_CYC);
                end
                S_BLK_FRAMES: fw_clr = 1'b1;
                default: ;
            endcase
        end
    end

    assign fw_en = (st_q == S_BLK_FRAMES);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_OFF;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_d != st_q) && (st_d == S_ON || st_d == S_OFF);
            if (st_q == S_OFF && pwr_on_req)
                fault_q <= 1'b0;
            else if (st_q == S_BLK_FRAMES && fw_to && !fw_goal)
                fault_q <= 1'b1;
        end
    end

    assign ctl          = ctl_of(st_q);
    assign panel_pwr_en = ctl.panel;
    assign video_en     = ctl.video;
    assign ser_enable   = ctl.ser;
    assign black_sel    = ctl.black;
    assign backlight_en = ctl.bl;
    assign seq_status   = status_of(st_q);
    assign seq_done     = done_q;
    assign frame_fault  = fault_q;
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       panel,
    input logic       video,
    input logic       ser,
    input logic       black,
    input logic       bl,
    input logic [1:0] status,
    input logic       done
);
    a_r2_video_needs_panel: assert property (@(posedge clk) disable iff (rst)
        video |-> panel);

    a_r2_ser_needs_video: assert property (@(posedge clk) disable iff (rst)
        ser |-> (video && panel));

    a_r2_bl_needs_image: assert property (@(posedge clk) disable iff (rst)
        bl |-> (ser && !black));

    a_r4_release_on_black: assert property (@(posedge clk) disable iff (rst)
        $rose(ser) |-> (black && $past(video)));

    a_r2_image_before_bl: assert property (@(posedge clk) disable iff (rst)
        $rose(bl) |-> $past(ser && !black));

    a_r5_shdn_under_black: assert property (@(posedge clk) disable iff (rst)
        $fell(ser) |-> (black && !bl));

    a_r8_video_off_after_shdn: assert property (@(posedge clk) disable iff (rst)
        $fell(video) |-> $past(!ser));

    a_r5_panel_off_last: assert property (@(posedge clk) disable iff (rst)
        $fell(panel) |-> (!video && $past(!video)));

    a_r1_off_is_dark: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd0) |-> (!ser && !bl && !video));

    a_r12_done_terminal: assert property (@(posedge clk) disable iff (rst)
        done |-> (status == 2'd0 || status == 2'd2));

    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .panel (panel_pwr_en),
    .video (video_en),
    .ser   (ser_enable),
    .black (black_sel),
    .bl    (backlight_en),
    .status(seq_status),
    .done  (seq_done)
);

// File: tb/tb_lcd_pwr_seq.sv
module tb_lcd_pwr_seq;
    localparam int CPU  = 2;
    localparam int CW   = 12;
    localparam int LOCK = 1001;
    localparam int GOAL = 3;
    localparam int TO   = 60;
    localparam int FP   = 30;
    localparam int SHC  = (CPU * 250 + 999) / 1000;
    localparam int BIG  = 1000000;

    localparam logic [4:0] V_OFF  = 5'b00010;
    localparam logic [4:0] V_RAMP = 5'b10010;
    localparam logic [4:0] V_VB   = 5'b11010;
    localparam logic [4:0] V_LOCK = 5'b11110;
    localparam logic [4:0] V_IMG  = 5'b11100;
    localparam logic [4:0] V_ON   = 5'b11101;
    localparam logic [4:0] V_SHD  = 5'b11010;
    localparam logic [4:0] V_POFF = 5'b10010;

    logic clk = 1'b0, rst = 1'b1;
    logic on_req = 1'b0, off_req = 1'b0, frame = 1'b0, frame_en = 1'b0;
    logic [CW-1:0] c_ramp = '0, c_settle = '0, c_bloff = '0;
    logic panel, video, black, ser, bl, done, fault;
    logic [1:0] status;

    lcd_pwr_seq #(
        .CYC_PER_US(CPU), .CFG_W(CW), .LOCK_US(LOCK),
        .BLACK_FRAMES(GOAL), .FRAME_TO_US(TO)
    ) dut (
        .clk(clk), .rst(rst), .pwr_on_req(on_req), .pwr_off_req(off_req),
        .frame_start(frame), .cfg_ramp_us(c_ramp), .cfg_settle_us(c_settle),
        .cfg_bloff_us(c_bloff), .panel_pwr_en(panel), .video_en(video),
        .black_sel(black), .ser_enable(ser), .backlight_en(bl),
        .seq_status(status), .seq_done(done), .frame_fault(fault)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic [4:0]  v;
        logic [1:0]  st;
        logic [31:0] mn;
        logic [31:0] mx;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    checks = 0, errors = 0, done_cnt = 0;
    bit    mon_on = 1'b0;
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [4:0] vec();
        return {panel, video, ser, black, bl};
    endfunction

    task automatic push(input logic [4:0] v, input logic [1:0] st,
                        input int mn, input int mx, input string tag);
        exp_t e;
        e.v = v; e.st = st; e.mn = 32'(mn); e.mx = 32'(mx);
        q.push_back(e);
        tq.push_back(tag);
    endtask

    // monitor: compares every strobe change against the scoreboard queue
    initial begin
        logic [4:0] prev;
        int last;
        wait (mon_on);
        prev = vec();
        last = cyc;
        forever begin
            @(negedge clk);
            if (done) done_cnt++;
            if (vec() !== prev) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected strobe change", longint'(vec()), longint'(prev));
                end else begin
                    exp_t  e;
                    string tag;
                    int    gap;
                    e   = q.pop_front();
                    tag = tq.pop_front();
                    gap = cyc - last;
                    chk(vec() == e.v, tag, "strobe vector", longint'(vec()), longint'(e.v));
                    chk(status == e.st, "R12", "status at step", longint'(status), longint'(e.st));
                    chk(gap >= int'(e.mn), tag, "step gap too short", gap, longint'(e.mn));
                    chk(gap <= int'(e.mx), tag, "step gap too long", gap, longint'(e.mx));
                end
                prev = vec();
                last = cyc;
            end
        end
    end

    // frame-start generator
    initial begin
        int fc = 0;
        forever begin
            @(negedge clk);
            fc++;
            frame = frame_en && (fc % FP == 0);
        end
    end

    task automatic pulse_on();
        @(negedge clk); on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
    endtask

    task automatic pulse_off();
        @(negedge clk); off_req = 1'b1;
        @(negedge clk); off_req = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_up(input int r, input int s);
        push(V_RAMP, 2'd1, 0, BIG, "R2");
        push(V_VB,   2'd1, (r + s) * CPU + 2, (r + s + 2) * CPU + 4, "R3");
        push(V_LOCK, 2'd1, 1, 1, "R2");
        push(V_IMG,  2'd1, LOCK * CPU + 1, (LOCK + 1) * CPU + 2, "R4");
        push(V_ON,   2'd2, 1, 1, "R2");
    endtask

    task automatic expect_tail();
        push(V_POFF, 2'd3, SHC + 1, SHC + 1, "R8");
        push(V_OFF,  2'd0, 1, 1, "R5");
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(vec() == V_OFF, "R1", "strobes after reset", longint'(vec()), longint'(V_OFF));
        chk(status == 2'd0, "R1", "status after reset", longint'(status), 0);
        chk(!done && !fault, "R1", "done/fault after reset", longint'({done, fault}), 0);
        mon_on = 1'b1;

        // full power-up
        c_ramp = 5; c_settle = 10; c_bloff = 20;
        repeat (5) @(negedge clk);
        d0 = done_cnt;
        expect_up(5, 10);
        pulse_on();
        drain();
        chk(status == 2'd2, "R12", "status on", longint'(status), 2);
        chk(done_cnt == d0 + 1, "R12", "done pulses on power-up", done_cnt, d0 + 1);

        // R10: power-on while on is ignored
        pulse_on();
        repeat (40) @(negedge clk);
        chk(status == 2'd2, "R10", "status after ignored on", longint'(status), 2);

        // R11: new backlight wait while on must not apply
        c_bloff = 200;
        frame_en = 1'b1;
        d0 = done_cnt;
        push(V_IMG, 2'd3, 0, BIG, "R5");
        push(V_LOCK, 2'd3, 20 * CPU + 1, 21 * CPU + 2, "R11");
        push(V_SHD, 2'd3, 2 * FP + 1, 3 * FP + 2, "R7");
        expect_tail();
        pulse_off();
        drain();
        chk(status == 2'd0, "R5", "status off", longint'(status), 0);
        chk(done_cnt == d0 + 1, "R12", "done pulses on power-down", done_cnt, d0 + 1);
        chk(!fault, "R13", "no fault with frames", longint'(fault), 0);

        // R10: power-off while off is ignored
        pulse_off();
        repeat (20) @(negedge clk);
        chk(status == 2'd0, "R10", "status after ignored off", longint'(status), 0);

        // second cycle with new timing, power-on ignored during power-down
        c_ramp = 3; c_settle = 0; c_bloff = 7;
        repeat (5) @(negedge clk);
        expect_up(3, 0);
        pulse_on();
        drain();
        push(V_IMG, 2'd3, 0, BIG, "R5");
        push(V_LOCK, 2'd3, 7 * CPU + 1, 8 * CPU + 2, "R6");
        push(V_SHD, 2'd3, 2 * FP + 1, 3 * FP + 2, "R7");
        expect_tail();
        pulse_off();
        repeat (3) @(negedge clk);
        chk(status == 2'd3, "R12", "status powering down", longint'(status), 3);
        pulse_on();
        drain();
        chk(status == 2'd0, "R10", "power-on ignored while going down", longint'(status), 0);

        // R9: abort during lock hold
        push(V_RAMP, 2'd1, 0, BIG, "R2");
        push(V_VB,   2'd1, 3 * CPU + 2, 5 * CPU + 4, "R3");
        push(V_LOCK, 2'd1, 1, 1, "R2");
        pulse_on();
        drain();
        repeat (10) @(negedge clk);
        push(V_SHD, 2'd3, 2 * FP + 1, BIG, "R9");
        expect_tail();
        pulse_off();
        drain();
        chk(status == 2'd0, "R9", "off after lock abort", longint'(status), 0);

        // R9: abort during supply ramp, video never enabled
        c_ramp = 50;
        repeat (5) @(negedge clk);
        push(V_RAMP, 2'd1, 0, BIG, "R2");
        pulse_on();
        drain();
        chk(status == 2'd1, "R12", "status powering up", longint'(status), 1);
        d0 = done_cnt;
        push(V_OFF, 2'd0, 0, BIG, "R9");
        pulse_off();
        drain();
        chk(done_cnt == d0 + 1, "R9", "done after ramp abort", done_cnt, d0 + 1);

        // R13: frame pulses stop during black counting
        c_ramp = 2; c_settle = 2; c_bloff = 4;
        repeat (5) @(negedge clk);
        expect_up(2, 2);
        pulse_on();
        drain();
        frame_en = 1'b0;
        push(V_IMG, 2'd3, 0, BIG, "R5");
        push(V_LOCK, 2'd3, 4 * CPU + 1, 5 * CPU + 2, "R6");
        push(V_SHD, 2'd3, (TO - 1) * CPU, (TO + 1) * CPU + 3, "R13");
        expect_tail();
        pulse_off();
        drain();
        chk(fault == 1'b1, "R13", "fault latched", longint'(fault), 1);
        repeat (10) @(negedge clk);
        chk(fault == 1'b1, "R13", "fault held while off", longint'(fault), 1);
        frame_en = 1'b1;
        expect_up(2, 2);
        pulse_on();
        chk(fault == 1'b0, "R13", "fault cleared by power-on", longint'(fault), 0);
        drain();
        chk(status == 2'd2, "R2", "on after fault recovery", longint'(status), 2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule